// File: doc/BRIEF.md
# Dual-Port In-Order Issue Arbiter

This block sits between the decode stage and the execution pipelines of an in-order core that has two issue ports. Each cycle it is shown the two oldest instructions, the older slot A and the younger slot B. Each slot carries a valid bit, a three-bit class code and a hold length. The arbiter decides which of them issue. It reports the ports each issued instruction takes and raises a stall when a valid instruction has to wait.

Execution unit 0 can be reached only through port 0, and execution unit 1 only through port 1. Some classes are pinned to one port. Dual instructions seize both ports and both units for their issue cycle. Complex instructions seize everything and then keep every unit busy for a programmable number of further cycles. A 32-bit multiply walks four multiplier stages and then claims port 0 for its result. While any multiplier stage is occupied, neither simple unit may be reserved. The arbiter holds the occupancy state for all of this in a small countdown and a stage shift register.

Top module: `dual_issue_arbiter`

## Requirements
- R1: Class codes are 0 = port-0 simple, 1 = port-1 simple, 2 = either-port simple, 3 = dual, 4 = complex, 5 = integer multiply. While reset is high every output is 0. After reset is released, a dual, complex or port-0 instruction issues in the first cycle.
- R2: Port masks use bit 0 for port 0 and bit 1 for port 1. When both slots hold either-port instructions and both ports are free, A gets mask 01 and B gets mask 10.
- R3: A port-0 simple instruction issues only with mask 01, and a port-1 simple instruction only with mask 10. Two issued instructions never share a port, so if both slots need the same pinned port, only A issues.
- R4: An either-port instruction takes port 1 (mask 10) when port 0 is unavailable. This happens when A already holds port 0, or when a multiply result claims port 0.
- R5: B issues only in a cycle in which A also issues. The stall output is 1 exactly when a valid slot does not issue.
- R6: A dual instruction issues with mask 11 and B is refused in that cycle. In the following cycle both ports are free again.
- R7: A complex instruction issues with mask 11 and takes the hold input N from its slot. In the N cycles after its issue cycle no instruction issues, and in the cycle after that, issue resumes.
- R8: A multiply issues with mask 00 and B is refused in that cycle. In the three cycles after issue, no simple, dual or complex instruction issues. A second multiply may issue in the very next cycle.
- R9: In the fourth cycle after a multiply issues, port 0 is taken. A port-0 simple instruction stalls there, while an either-port instruction issues on port 1.
- R10: Class codes 6 and 7 never issue, and they block B.
- R11: Reset clears a running complex hold and in-flight multiply stages, so that a port-0 instruction issues in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_valid | input | 1 | Older slot holds an instruction |
| a_class | input | 3 | Older slot class code |
| a_hold | input | HOLD_W | Older slot extra busy cycles (complex only) |
| b_valid | input | 1 | Younger slot holds an instruction |
| b_class | input | 3 | Younger slot class code |
| b_hold | input | HOLD_W | Younger slot extra busy cycles (complex only) |
| a_issue | output | 1 | Older instruction issues this cycle |
| a_ports | output | 2 | Ports taken by the older instruction |
| b_issue | output | 1 | Younger instruction issues this cycle |
| b_ports | output | 2 | Ports taken by the younger instruction |
| stall | output | 1 | A valid slot was refused this cycle |

## Verification
The case that matters most is when a multiply result's claim on port 0 falls in the same cycle as a new pair that wants port 0. The bench sets this up by issuing a multiply and then offering an either-port instruction in A and a port-0 instruction in B exactly four cycles later. The expected outcome is that A moves to port 1, B is held and stall rises. A second overlap is a complex hold that is still counting down when reset arrives; it is judged by whether a port-0 instruction issues in the first cycle after reset.

// File: rtl/dpia_pkg.sv
package dpia_pkg;

    typedef enum logic [2:0] {
        CLS_P0   = 3'd0,
        CLS_P1   = 3'd1,
        CLS_ANY  = 3'd2,
        CLS_DUAL = 3'd3,
        CLS_CPLX = 3'd4,
        CLS_IMUL = 3'd5,
        CLS_RSV6 = 3'd6,
        CLS_RSV7 = 3'd7
    } cls_e;

    localparam int MUL_STAGES = 4;

    // Availability (or, used as a claim, the resources taken) in one cycle.
    typedef struct packed {
        logic p0;       // issue port 0
        logic p1;       // issue port 1
        logic e0;       // simple unit 0 reservable
        logic e1;       // simple unit 1 reservable
        logic m1;       // first multiplier stage
        logic mrest;    // multiplier stages 2..4
        logic eu_clear; // no simple unit reserved by anyone this cycle
    } res_t;

    // Remove the resources of one claim from an availability set.
    function automatic res_t res_take(res_t avail, res_t claim);
        res_t r;
        r          = avail;
        r.p0       = avail.p0 & ~claim.p0;
        r.p1       = avail.p1 & ~claim.p1;
        r.e0       = avail.e0 & ~claim.e0 & ~claim.m1;
        r.e1       = avail.e1 & ~claim.e1 & ~claim.m1;
        r.m1       = avail.m1 & ~claim.m1;
        r.mrest    = avail.mrest & ~claim.mrest;
        r.eu_clear = avail.eu_clear & ~claim.e0 & ~claim.e1;
        return r;
    endfunction

endpackage

// File: rtl/dpia_slot_fit.sv
module dpia_slot_fit
    import dpia_pkg::*;
(
    input  logic       vld,
    input  logic [2:0] cls,
    input  res_t       avail,
    output logic       grant,
    output res_t       claim,
    output logic [1:0] ports
);

    res_t want;
    logic ok;

    always_comb begin
        want = '0;
        ok   = 1'b0;
        case (cls)
            CLS_P0: begin
                ok      = avail.p0 & avail.e0;
                want.p0 = 1'b1;
                want.e0 = 1'b1;
            end
            CLS_P1: begin
                ok      = avail.p1 & avail.e1;
                want.p1 = 1'b1;
                want.e1 = 1'b1;
            end
            CLS_ANY: begin
                if (avail.p0 && avail.e0) begin
                    ok      = 1'b1;
                    want.p0 = 1'b1;
                    want.e0 = 1'b1;
                end else begin
                    ok      = avail.p1 & avail.e1;
                    want.p1 = 1'b1;
                    want.e1 = 1'b1;
                end
            end
            CLS_DUAL: begin
                ok      = avail.p0 & avail.p1 & avail.e0 & avail.e1;
                want.p0 = 1'b1;
                want.p1 = 1'b1;
                want.e0 = 1'b1;
                want.e1 = 1'b1;
            end
            CLS_CPLX: begin
                ok         = avail.p0 & avail.p1 & avail.e0 & avail.e1
                           & avail.m1 & avail.mrest;
                want.p0    = 1'b1;
                want.p1    = 1'b1;
                want.e0    = 1'b1;
                want.e1    = 1'b1;
                want.m1    = 1'b1;
                want.mrest = 1'b1;
            end
            CLS_IMUL: begin
                ok      = avail.m1 & avail.eu_clear;
                want.m1 = 1'b1;
            end
            default: begin
                ok = 1'b0;
            end
        endcase
        grant = vld & ok;
        claim = grant ? want : '0;
        ports = {claim.p1, claim.p0};
    end

endmodule

// File: rtl/dpia_hold_track.sv
module dpia_hold_track #(
    parameter int HOLD_W = 6,
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cplx_go,
    input  logic [HOLD_W-1:0] cplx_len,
    input  logic              mul_go,
    output logic              all_busy,
    output logic              stages_busy,
    output logic              port0_claim
);

    localparam int LAST = STAGES - 1;

    logic [HOLD_W-1:0] cnt;
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cplx_go) begin
            cnt <= cplx_len;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // sh[k] set: a multiply issued k+1 cycles ago. The top bit marks the
    // cycle in which its result claims port 0.
    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else begin
            sh <= {sh[LAST-1:0], mul_go};
        end
    end

    assign all_busy    = (cnt != '0);
    assign stages_busy = |sh[LAST-1:0];
    assign port0_claim = sh[LAST];

    assert_hold_countdown_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(cnt) != '0 && !$past(cplx_go) && !$past(rst)) |-> (cnt == $past(cnt) - 1'b1));

    assert_hold_load_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(cplx_go) && !$past(rst)) |-> (cnt == $past(cplx_len)));

endmodule

// File: rtl/dual_issue_arbiter.sv
module dual_issue_arbiter
    import dpia_pkg::*;
#(
    parameter int HOLD_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_valid,
    input  logic [2:0]        a_class,
    input  logic [HOLD_W-1:0] a_hold,
    input  logic              b_valid,
    input  logic [2:0]        b_class,
    input  logic [HOLD_W-1:0] b_hold,
    output logic              a_issue,
    output logic [1:0]        a_ports,
    output logic              b_issue,
    output logic [1:0]        b_ports,
    output logic              stall
);

    logic all_busy, stages_busy, port0_claim;
    res_t avail_a, avail_b, claim_a, claim_b;
    logic grant_a, grant_b;
    logic [1:0] ports_a, ports_b;
    logic mul_go, cplx_go;
    logic [HOLD_W-1:0] cplx_len;

    always_comb begin
        avail_a.p0       = ~port0_claim;
        avail_a.p1       = 1'b1;
        avail_a.e0       = ~all_busy & ~stages_busy;
        avail_a.e1       = ~all_busy & ~stages_busy;
        avail_a.m1       = ~all_busy;
        avail_a.mrest    = ~stages_busy;
        avail_a.eu_clear = 1'b1;
    end

    dpia_slot_fit u_fit_a (
        .vld   (a_valid & ~rst),
        .cls   (a_class),
        .avail (avail_a),
        .grant (grant_a),
        .claim (claim_a),
        .ports (ports_a)
    );

    assign avail_b = res_take(avail_a, claim_a);

    dpia_slot_fit u_fit_b (
        .vld   (b_valid & grant_a),
        .cls   (b_class),
        .avail (avail_b),
        .grant (grant_b),
        .claim (claim_b),
        .ports (ports_b)
    );

    assign a_issue = grant_a;
    assign a_ports = ports_a;
    assign b_issue = grant_b;
    assign b_ports = ports_b;
    assign stall   = ~rst & ((a_valid & ~grant_a) | (b_valid & ~grant_b));

    assign mul_go   = (grant_a && a_class == CLS_IMUL) || (grant_b && b_class == CLS_IMUL);
    assign cplx_go  = (grant_a && a_class == CLS_CPLX) || (grant_b && b_class == CLS_CPLX);
    assign cplx_len = (grant_a && a_class == CLS_CPLX) ? a_hold : b_hold;

    dpia_hold_track #(
        .HOLD_W (HOLD_W),
        .STAGES (MUL_STAGES)
    ) u_track (
        .clk         (clk),
        .rst         (rst),
        .cplx_go     (cplx_go),
        .cplx_len    (cplx_len),
        .mul_go      (mul_go),
        .all_busy    (all_busy),
        .stages_busy (stages_busy),
        .port0_claim (port0_claim)
    );

    assert_no_port_clash_R3: assert property (@(posedge clk) disable iff (rst)
        (a_issue && b_issue) |-> ((a_ports & b_ports) == 2'b00));

    assert_claims_disjoint_R3: assert property (@(posedge clk) disable iff (rst)
        ((claim_a & claim_b) == '0));

    assert_in_order_R5: assert property (@(posedge clk) disable iff (rst)
        b_issue |-> a_issue);

    assert_hold_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        all_busy |-> (!a_issue && !b_issue));

    assert_mul_excl_R8: assert property (@(posedge clk) disable iff (rst)
        stages_busy |-> (!claim_a.e0 && !claim_a.e1 && !claim_b.e0 && !claim_b.e1));

    assert_mul_port_R9: assert property (@(posedge clk) disable iff (rst)
        port0_claim |-> (!a_ports[0] && !b_ports[0]));

    assert_reserved_R10: assert property (@(posedge clk) disable iff (rst)
        (a_class == CLS_RSV6 || a_class == CLS_RSV7) |-> !a_issue);

endmodule

// File: tb/test_dual_issue_arbiter.sv
module test_dual_issue_arbiter;
    import dpia_pkg::*;

    localparam int HW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_valid = 1'b0, b_valid = 1'b0;
    logic [2:0] a_class = '0, b_class = '0;
    logic [HW-1:0] a_hold = '0, b_hold = '0;
    logic a_issue, b_issue, stall;
    logic [1:0] a_ports, b_ports;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dual_issue_arbiter #(.HOLD_W(HW)) i_dual_issue_arbiter (
        .clk(clk), .rst(rst),
        .a_valid(a_valid), .a_class(a_class), .a_hold(a_hold),
        .b_valid(b_valid), .b_class(b_class), .b_hold(b_hold),
        .a_issue(a_issue), .a_ports(a_ports),
        .b_issue(b_issue), .b_ports(b_ports), .stall(stall)
    );

    // Drive one cycle's pair at the falling edge, then let outputs settle.
    task automatic put(input logic av, input logic [2:0] ac, input logic [HW-1:0] ah,
                       input logic bv, input logic [2:0] bc);
        @(negedge clk);
        a_valid = av; a_class = ac; a_hold = ah;
        b_valid = bv; b_class = bc; b_hold = '0;
        #1;
    endtask

    task automatic expect_out(input string tag, input logic ai, input logic [1:0] ap,
                              input logic bi, input logic [1:0] bp, input logic st);
        logic [6:0] got, exp;
        got = {a_issue, a_ports, b_issue, b_ports, stall};
        exp = {ai, ap, bi, bp, st};
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got{ai,ap,bi,bp,st}=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(1'b0, CLS_P0, '0, 1'b0, CLS_P0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(negedge clk);
        a_valid = 1'b1; a_class = CLS_DUAL; b_valid = 1'b1; b_class = CLS_P1;
        #1;
        expect_out("R1 outputs quiet in reset", 0, 2'b00, 0, 2'b00, 0);
        @(negedge clk);
        rst = 1'b0;
        a_valid = 1'b0; b_valid = 1'b0;
        #1;
        expect_out("R1 idle after reset", 0, 2'b00, 0, 2'b00, 0);
        put(1'b1, CLS_DUAL, '0, 1'b0, CLS_P0);
        expect_out("R1 dual issues after reset", 1, 2'b11, 0, 2'b00, 0);
        put(1'b1, CLS_CPLX, 6'd0, 1'b0, CLS_P0);
        expect_out("R1 complex issues after reset", 1, 2'b11, 0, 2'b00, 0);
    endtask

    task automatic t_either_pair();
        put(1'b1, CLS_ANY, '0, 1'b1, CLS_ANY);
        expect_out("R2 either pair older on port0", 1, 2'b01, 1, 2'b10, 0);
    endtask

    task automatic t_pinned();
        put(1'b1, CLS_P0, '0, 1'b1, CLS_P0);
        expect_out("R3 both port0 younger held", 1, 2'b01, 0, 2'b00, 1);
        put(1'b1, CLS_P1, '0, 1'b1, CLS_P1);
        expect_out("R3 both port1 younger held", 1, 2'b10, 0, 2'b00, 1);
        put(1'b1, CLS_P1, '0, 1'b1, CLS_P0);
        expect_out("R3 port1 then port0", 1, 2'b10, 1, 2'b01, 0);
    endtask

    task automatic t_fallback();
        put(1'b1, CLS_P0, '0, 1'b1, CLS_ANY);
        expect_out("R4 either falls to port1", 1, 2'b01, 1, 2'b10, 0);
        put(1'b1, CLS_P1, '0, 1'b1, CLS_ANY);
        expect_out("R4 either takes port0 after port1", 1, 2'b10, 1, 2'b01, 0);
    endtask

    task automatic t_order();
        put(1'b0, CLS_P0, '0, 1'b1, CLS_P1);
        expect_out("R5 younger waits for empty older", 0, 2'b00, 0, 2'b00, 1);
        put(1'b1, CLS_RSV6, '0, 1'b1, CLS_P1);
        expect_out("R5 younger waits for blocked older", 0, 2'b00, 0, 2'b00, 1);
    endtask

    task automatic t_dual();
        put(1'b1, CLS_DUAL, '0, 1'b1, CLS_P1);
        expect_out("R6 dual takes both ports", 1, 2'b11, 0, 2'b00, 1);
        put(1'b1, CLS_P0, '0, 1'b1, CLS_P1);
        expect_out("R6 ports free after dual", 1, 2'b01, 1, 2'b10, 0);
    endtask

    task automatic t_complex();
        put(1'b1, CLS_CPLX, 6'd3, 1'b0, CLS_P0);
        expect_out("R7 complex issue", 1, 2'b11, 0, 2'b00, 0);
        for (int i = 0; i < 3; i++) begin
            put(1'b1, CLS_P1, '0, 1'b0, CLS_P0);
            expect_out("R7 hold blocks issue", 0, 2'b00, 0, 2'b00, 1);
        end
        put(1'b1, CLS_P1, '0, 1'b0, CLS_P0);
        expect_out("R7 issue resumes after hold", 1, 2'b10, 0, 2'b00, 0);
    endtask

    task automatic t_multiply();
        put(1'b1, CLS_IMUL, '0, 1'b1, CLS_P1);
        expect_out("R8 multiply issues portless", 1, 2'b00, 0, 2'b00, 1);
        put(1'b1, CLS_P1, '0, 1'b0, CLS_P0);
        expect_out("R8 simple blocked stage2", 0, 2'b00, 0, 2'b00, 1);
        put(1'b1, CLS_DUAL, '0, 1'b0, CLS_P0);
        expect_out("R8 dual blocked stage3", 0, 2'b00, 0, 2'b00, 1);
        put(1'b1, CLS_CPLX, 6'd1, 1'b0, CLS_P0);
        expect_out("R8 complex blocked stage4", 0, 2'b00, 0, 2'b00, 1);
        put(1'b1, CLS_ANY, '0, 1'b1, CLS_P0);
        expect_out("R9 result cycle port0 taken", 1, 2'b10, 0, 2'b00, 1);
        put(1'b1, CLS_P0, '0, 1'b0, CLS_P0);
        expect_out("R9 port0 free after result", 1, 2'b01, 0, 2'b00, 0);
    endtask

    task automatic t_mul_pipe();
        put(1'b1, CLS_IMUL, '0, 1'b0, CLS_P0);
        expect_out("R8 first multiply", 1, 2'b00, 0, 2'b00, 0);
        put(1'b1, CLS_IMUL, '0, 1'b0, CLS_P0);
        expect_out("R8 back to back multiply", 1, 2'b00, 0, 2'b00, 0);
        idle(2);
        put(1'b1, CLS_P0, '0, 1'b0, CLS_P0);
        expect_out("R9 port0 simple held on result", 0, 2'b00, 0, 2'b00, 1);
        idle(2);
    endtask

    task automatic t_reserved();
        put(1'b1, CLS_RSV7, '0, 1'b1, CLS_ANY);
        expect_out("R10 code 7 never issues", 0, 2'b00, 0, 2'b00, 1);
        put(1'b1, CLS_RSV6, '0, 1'b0, CLS_P0);
        expect_out("R10 code 6 never issues", 0, 2'b00, 0, 2'b00, 1);
    endtask

    task automatic t_reset_mid();
        put(1'b1, CLS_CPLX, 6'd20, 1'b0, CLS_P0);
        expect_out("R11 long complex issue", 1, 2'b11, 0, 2'b00, 0);
        put(1'b1, CLS_P0, '0, 1'b0, CLS_P0);
        expect_out("R11 hold active before reset", 0, 2'b00, 0, 2'b00, 1);
        a_valid = 1'b0;
        do_reset();
        put(1'b1, CLS_P0, '0, 1'b0, CLS_P0);
        expect_out("R11 hold cleared by reset", 1, 2'b01, 0, 2'b00, 0);
        put(1'b1, CLS_IMUL, '0, 1'b0, CLS_P0);
        expect_out("R11 multiply before reset", 1, 2'b00, 0, 2'b00, 0);
        a_valid = 1'b0;
        do_reset();
        put(1'b1, CLS_P0, '0, 1'b0, CLS_P0);
        expect_out("R11 stages cleared by reset", 1, 2'b01, 0, 2'b00, 0);
    endtask

    initial begin
        t_reset();
        t_either_pair();
        t_pinned();
        t_fallback();
        t_order();
        t_dual();
        t_complex();
        t_multiply();
        t_mul_pipe();
        t_reserved();
        t_reset_mid();
        idle(1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired got=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule